// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

The walker follows a chain of 64-bit scatter-gather descriptors held in memory. A start pulse loads a table base address and an expected total byte count. The walker then reads one descriptor at a time over a simple request/acknowledge read port and decodes its action code. It hands each transfer descriptor to a downstream data mover as an address/length request, follows link descriptors to a new table location, and steps over no-op and reserved entries. It stops when it reaches the descriptor whose end flag is set.

Each descriptor holds a 32-bit address in bits 63..32 and a 16-bit length in bits 31..16. Bits 15..6 and bit 3 are reserved and must be zero. Bit 5 and bit 4 form the action code {b5,b4}: 00 no-op, 01 reserved (skip), 10 transfer, 11 link. Bit 2 requests an interrupt, bit 1 marks the end of the chain and bit 0 marks the entry valid.

The walker raises an interrupt pulse and a done pulse. It also keeps an error status that records the error kind, the state the engine was in when the error was detected, and the address of the descriptor that caused it. This status stays valid until the next start. The walker does not move any data itself.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset the walker is idle: mem_req_o, xfer_valid_o, busy_o, done_o, irq_o and err_o are all 0.
- R2: A start pulse in idle fetches the first descriptor at base_addr_i. mem_req_o and mem_addr_o are held until mem_ack_i. Descriptors that do not redirect the walk are fetched from consecutive addresses 8 bytes apart.
- R3: A transfer descriptor (action 10) drives xfer_valid_o with xfer_addr_o taken from bits 63..32 and xfer_len_o taken from bits 31..16. These values are held stable until xfer_ready_i is 1.
- R4: A length field of zero requests 65536 bytes (xfer_len_o = 0x10000).
- R5: A link descriptor (action 11) causes the next fetch at the address in bits 63..32 and issues no transfer.
- R6: No-op (action 00) and reserved (action 01) descriptors issue no transfer. The walk continues at the next descriptor, 8 bytes further on.
- R7: A descriptor with bit 2 set produces a one-cycle irq_o pulse in the cycle after its action completes. For a transfer, the action completes at the transfer handshake.
- R8: After the action of a descriptor with bit 1 set, done_o pulses for one cycle, busy_o drops and no further descriptor is fetched.
- R9: A descriptor with bit 0 clear, or with non-zero reserved bits, stops the walk with err_kind_o = 1 (descriptor error). No transfer is issued and done_o is not asserted.
- R10: A transfer descriptor whose address or length is not a multiple of 4 stops the walk with err_kind_o = 1 and issues no transfer.
- R11: If the total length transferred at the end of the chain differs from expect_bytes_i, the walk ends with err_kind_o = 2 (length mismatch) instead of done_o.
- R12: On any error, err_o is 1. err_state_o holds the state at detection (2 = decoding a descriptor, 3 = transfer handshake) and err_addr_o holds the failing descriptor's address. All three hold until the next start, which clears them.
- R13: start_i is ignored while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| base_addr_i | input | AW | Address of the first descriptor |
| expect_bytes_i | input | TW | Expected total transfer length in bytes |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | AW | Descriptor read address |
| mem_ack_i | input | 1 | Read response valid |
| mem_rdata_i | input | AW+32 | Descriptor read data |
| xfer_valid_o | output | 1 | Transfer request valid |
| xfer_addr_o | output | AW | Transfer data address |
| xfer_len_o | output | LW+1 | Transfer length in bytes |
| xfer_ready_i | input | 1 | Data mover accepts the request |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Chain completed without error (pulse) |
| irq_o | output | 1 | Descriptor interrupt (pulse) |
| err_o | output | 1 | Error status present |
| err_kind_o | output | 2 | 0 none, 1 descriptor error, 2 length mismatch |
| err_state_o | output | 2 | Engine state at error detection |
| err_addr_o | output | AW | Address of the failing descriptor |

## Verification
A wrong descriptor pointer shows up at the read port as a wrong fetch address, on the very next fetch. A wrong action decode shows up as a missing or extra transfer request, or as the walk continuing past its end marker. A corrupted byte accumulator stays hidden until the end descriptor is processed, where it flips done into a length-mismatch error. The bench therefore logs every fetch address, every transfer handshake and the cycle of each pulse, and compares them with lists derived from the descriptor tables it writes.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_ACT = 2'd2, ST_XFER = 2'd3} sgw_state_e;
  typedef enum logic [1:0] {ACT_NOP = 2'd0, ACT_SKIP = 2'd1, ACT_XFER = 2'd2, ACT_LINK = 2'd3} sgw_act_e;
  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_DESC = 2'd1, ERR_LEN = 2'd2} sgw_err_e;
  localparam int unsigned DESC_STRIDE = 8;
endpackage

// File: rtl/sgw_decode.sv
module sgw_decode import sgw_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  localparam int unsigned DW = AW + 32
) (
  input  logic [DW-1:0] desc_i,
  output logic          valid_o,
  output logic          last_o,
  output logic          intr_o,
  output sgw_act_e      act_o,
  output logic [AW-1:0] addr_o,
  output logic [LW:0]   len_o,
  output logic          misaligned_o
);
  logic [LW-1:0] len_field;
  logic          rsvd_bad;

  assign len_field    = desc_i[16 +: LW];
  // reserved bits must be zero, otherwise the entry is treated as not valid
  assign rsvd_bad     = (desc_i[31:16+LW] != '0) || (desc_i[15:6] != '0) || desc_i[3];
  assign valid_o      = desc_i[0] && !rsvd_bad;
  assign last_o       = desc_i[1];
  assign intr_o       = desc_i[2];
  assign act_o        = sgw_act_e'(desc_i[5:4]);
  assign addr_o       = desc_i[DW-1:32];
  assign len_o        = (len_field == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, len_field};
  assign misaligned_o = (addr_o[1:0] != 2'b00) || (len_field[1:0] != 2'b00);
endmodule

// File: rtl/sgw_len_acc.sv
module sgw_len_acc #(
  parameter int unsigned LW = 16,
  parameter int unsigned TW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [LW:0]   len_i,
  input  logic [TW-1:0] expect_i,
  output logic          mismatch_o
);
  logic [TW-1:0] sum_q, sum_d;

  assign sum_d      = sum_q + (add_i ? TW'(len_i) : '0);
  assign mismatch_o = (sum_d != expect_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else            sum_q <= sum_d;
  end
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker import sgw_pkg::*; #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter int unsigned TW = 32,
  localparam int unsigned DW = AW + 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [TW-1:0] expect_bytes_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          xfer_valid_o,
  output logic [AW-1:0] xfer_addr_o,
  output logic [LW:0]   xfer_len_o,
  input  logic          xfer_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          err_o,
  output logic [1:0]    err_kind_o,
  output logic [1:0]    err_state_o,
  output logic [AW-1:0] err_addr_o
);
  sgw_state_e    st_q;
  sgw_err_e      err_kind_q;
  sgw_state_e    err_state_q;
  logic [AW-1:0] cur_q, err_addr_q, next_addr;
  logic [DW-1:0] desc_q;
  logic          done_q, irq_q;

  logic          d_valid, d_last, d_intr, d_mis;
  sgw_act_e      d_act;
  logic [AW-1:0] d_addr;
  logic [LW:0]   d_len;
  logic          accept, hs, fin, bad, mismatch;

  sgw_decode #(.AW(AW), .LW(LW)) u_dec (
    .desc_i(desc_q), .valid_o(d_valid), .last_o(d_last), .intr_o(d_intr),
    .act_o(d_act), .addr_o(d_addr), .len_o(d_len), .misaligned_o(d_mis)
  );

  assign accept = (st_q == ST_IDLE) && start_i;
  assign hs     = (st_q == ST_XFER) && xfer_ready_i;

  sgw_len_acc #(.LW(LW), .TW(TW)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .add_i(hs),
    .len_i(d_len), .expect_i(expect_bytes_i), .mismatch_o(mismatch)
  );

  assign bad       = (st_q == ST_ACT) && (!d_valid || (d_act == ACT_XFER && d_mis));
  assign fin       = ((st_q == ST_ACT) && !bad && d_act != ACT_XFER) || hs;
  assign next_addr = (d_act == ACT_LINK) ? d_addr : cur_q + AW'(DESC_STRIDE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      desc_q      <= '0;
      done_q      <= 1'b0;
      irq_q       <= 1'b0;
      err_kind_q  <= ERR_NONE;
      err_state_q <= ST_IDLE;
      err_addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      if (accept) begin
        cur_q       <= base_addr_i;
        err_kind_q  <= ERR_NONE;
        err_state_q <= ST_IDLE;
        err_addr_q  <= '0;
        st_q        <= ST_FETCH;
      end
      if (st_q == ST_FETCH && mem_ack_i) begin
        desc_q <= mem_rdata_i;
        st_q   <= ST_ACT;
      end
      if (st_q == ST_ACT && !bad && d_act == ACT_XFER) st_q <= ST_XFER;
      if (bad) begin
        err_kind_q  <= ERR_DESC;
        err_state_q <= st_q;
        err_addr_q  <= cur_q;
        st_q        <= ST_IDLE;
      end
      if (fin) begin
        irq_q <= d_intr;
        if (d_last) begin
          st_q <= ST_IDLE;
          if (mismatch) begin
            err_kind_q  <= ERR_LEN;
            err_state_q <= st_q;
            err_addr_q  <= cur_q;
          end else begin
            done_q <= 1'b1;
          end
        end else begin
          cur_q <= next_addr;
          st_q  <= ST_FETCH;
        end
      end
    end
  end

  assign mem_req_o    = (st_q == ST_FETCH);
  assign mem_addr_o   = cur_q;
  assign xfer_valid_o = (st_q == ST_XFER);
  assign xfer_addr_o  = d_addr;
  assign xfer_len_o   = d_len;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign irq_o        = irq_q;
  assign err_o        = (err_kind_q != ERR_NONE);
  assign err_kind_o   = err_kind_q;
  assign err_state_o  = err_state_q;
  assign err_addr_o   = err_addr_q;

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  p_xfer_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_len_o));
  p_xfer_aligned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> (xfer_addr_o[1:0] == 2'b00) && (xfer_len_o[1:0] == 2'b00));
  p_irq_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !err_o && !busy_o);
  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && !xfer_valid_o);
  p_busy_start_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !fin && !bad |=> busy_o && $stable(mem_addr_o));
endmodule

// File: tb/sg_desc_walker_test.sv
module sg_desc_walker_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base = '0, expect_b = '0;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = '0;
  logic        xv, xr;
  logic [31:0] xa;
  logic [16:0] xl;
  logic        busy, done, irq, err;
  logic [1:0]  ekind, estate;
  logic [31:0] eaddr;

  logic [63:0] mem [0:63];
  int checks = 0, fails = 0, cyc = 0;
  bit stall = 0;
  logic [1:0] rcnt = '0;
  int n_x, n_f, n_irq, n_done, hs_cyc, irq_cyc;
  logic [31:0] x_a [0:15];
  logic [16:0] x_l [0:15];
  logic [31:0] f_a [0:15];

  always #5 clk = ~clk;

  sg_desc_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base), .expect_bytes_i(expect_b),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .xfer_valid_o(xv), .xfer_addr_o(xa), .xfer_len_o(xl), .xfer_ready_i(xr),
    .busy_o(busy), .done_o(done), .irq_o(irq), .err_o(err),
    .err_kind_o(ekind), .err_state_o(estate), .err_addr_o(eaddr)
  );

  assign xr = stall ? (rcnt == 2'd3) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rcnt <= rcnt + 2'd1;
    mem_ack <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[8:3]];
    if (mem_req && mem_ack && n_f < 16) begin f_a[n_f] = mem_addr; n_f = n_f + 1; end
    if (xv && xr && n_x < 16) begin x_a[n_x] = xa; x_l[n_x] = xl; n_x = n_x + 1; hs_cyc = cyc; end
    if (irq) begin n_irq = n_irq + 1; irq_cyc = cyc; end
    if (done) n_done = n_done + 1;
  end

  function automatic logic [63:0] mk(input logic [31:0] a, input logic [15:0] l, input logic [5:0] at);
    return {a, l, 10'b0, at};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] b, input logic [31:0] e, input bit inject);
    n_x = 0; n_f = 0; n_irq = 0; n_done = 0; hs_cyc = -1; irq_cyc = -1;
    @(negedge clk); start = 1'b1; base = b; expect_b = e;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (inject && i == 4) begin start = 1'b1; base = 32'h140; end
      else start = 1'b0;
      if (!busy && i > 0) break;
      @(negedge clk);
      if (i == 2999) chk(0, "R8", "walk timeout", 0, 1);
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!mem_req && !xv && !busy && !done && !irq && !err, "R1", "idle outputs",
        {mem_req, xv, busy, done, irq, err}, 0);
  endtask

  task automatic t_chain(input bit inject);
    run(32'h0, 32'd65600, inject);
    chk(n_f == 5, "R2", "fetch count", n_f, 5);
    chk(f_a[0] == 32'h0 && f_a[1] == 32'h8 && f_a[2] == 32'h10 && f_a[3] == 32'h18, "R6",
        "sequential fetches", {f_a[1][7:0], f_a[2][7:0], f_a[3][7:0]}, 24'h08_10_18);
    chk(f_a[4] == 32'h80, "R5", "link target fetch", f_a[4], 32'h80);
    chk(n_x == 2, "R6", "transfer count", n_x, 2);
    chk(x_a[0] == 32'h1000 && x_l[0] == 17'd64, "R3", "first transfer", {x_a[0], 15'b0, x_l[0]}, {32'h1000, 32'd64});
    chk(x_a[1] == 32'h2000 && x_l[1] == 17'h10000, "R4", "zero length is 64K", x_l[1], 17'h10000);
    chk(n_irq == 1, "R7", "irq on no-op", n_irq, 1);
    chk(n_done == 1 && !err && !busy, "R8", "done once, idle", n_done, 1);
    if (inject) chk(ekind == 2'd0, "R13", "start ignored while busy", ekind, 0);
  endtask

  task automatic t_stall;
    stall = 1;
    run(32'h100, 32'd8, 0);
    stall = 0;
    chk(n_x == 1 && x_a[0] == 32'h3000 && x_l[0] == 17'd8, "R3", "stalled transfer", x_l[0], 8);
    chk(irq_cyc == hs_cyc + 1, "R7", "irq after handshake", irq_cyc - hs_cyc, 1);
    chk(n_done == 1 && n_f == 1, "R8", "end stops fetching", n_f, 1);
  endtask

  task automatic t_invalid;
    run(32'h140, 32'd0, 0);
    chk(err && ekind == 2'd1 && n_x == 0 && n_done == 0, "R9", "invalid entry", ekind, 1);
    chk(estate == 2'd2 && eaddr == 32'h140, "R12", "error state/addr", {estate, eaddr}, {2'd2, 32'h140});
    run(32'h1c8, 32'd0, 0);
    chk(ekind == 2'd1 && n_x == 0 && eaddr == 32'h1c8, "R9", "reserved bit set", ekind, 1);
  endtask

  task automatic t_misaligned;
    run(32'h180, 32'd16, 0);
    chk(ekind == 2'd1 && n_x == 0, "R10", "misaligned address", ekind, 1);
    run(32'h1c0, 32'd18, 0);
    chk(ekind == 2'd1 && n_x == 0 && eaddr == 32'h1c0, "R10", "misaligned length", ekind, 1);
  endtask

  task automatic t_mismatch;
    run(32'h100, 32'd16, 0);
    chk(ekind == 2'd2 && n_done == 0 && n_x == 1, "R11", "length mismatch", ekind, 2);
    chk(estate == 2'd3 && eaddr == 32'h100, "R12", "mismatch state/addr", {estate, eaddr}, {2'd3, 32'h100});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = mk(32'h0,    16'h0,  6'h05);
    mem[1]  = mk(32'h1000, 16'h40, 6'h21);
    mem[2]  = mk(32'h0,    16'h0,  6'h11);
    mem[3]  = mk(32'h80,   16'h0,  6'h31);
    mem[16] = mk(32'h2000, 16'h0,  6'h23);
    mem[32] = mk(32'h3000, 16'h8,  6'h27);
    mem[40] = mk(32'h3000, 16'h8,  6'h20);
    mem[48] = mk(32'h4002, 16'h10, 6'h23);
    mem[56] = mk(32'h4000, 16'h12, 6'h23);
    mem[57] = mk(32'h4000, 16'h10, 6'h2b);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_chain(0);
    t_stall();
    t_invalid();
    t_misaligned();
    t_mismatch();
    t_chain(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule